// File: doc/BRIEF.md
# Dual Reference Frequency Qualifier

This block watches two reference clocks, already brought into the local clock domain, and raises one qualification flag for each of them. Each flag says two things: the reference is toggling, and its rate lies inside an accepted window around nominal. The channels share only the local clock and reset. Each one runs its own measurement and its own timers, so a fault on one reference never disturbs the flag of the other.

Each channel measures rate by counting rising edges of its reference during a gate of fixed length, timed in local clock cycles. The gate total is then compared with a lower and an upper count bound. The flag is deliberately asymmetric. A separate idle watchdog drops it quickly when edges stop. Only after the in-range state has held for a long settling time, with no failed gate and no loss of edges, does the flag rise. This stops the flag from chattering when a reference sits close to a window edge.

With the default values (125 MHz local clock, 19.44 MHz references, 100 ms gate, ±18 counts, which is roughly ±9.2 ppm), the idle limit is 400 µs and the settling time is 4 s.

Top module: `refq_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, every valid flag is 0.
- R2: A rising edge is counted in the cycle where the sampled reference is 1 and was 0 one cycle earlier. At the end of each GATE_CYCLES-cycle gate, the total (including an edge in the final gate cycle) is judged in range exactly when CNT_LO <= total <= CNT_HI.
- R3: A valid flag rises only when its channel has been in the in-range state for STABLE_CYCLES consecutive cycles. The in-range state is entered by an in-range gate result.
- R4: When no rising edge appears for LOS_CYCLES cycles, the channel is marked lost and its flag is 0 one cycle later, without waiting for the gate to end.
- R5: An out-of-range gate result clears the flag and restarts the settling period from zero.
- R6: A reference whose gate results alternate between in range and out of range more often than once per settling period never raises its flag.
- R7: The two channels are independent. Stopping or detuning one reference leaves the other flag unchanged.
- R8: The flag reads 0 both for a reference that runs too fast and for one that runs too slow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; times the gates and all timers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ref_in | input | NUM_REF | Reference levels, already synchronised to clk; bit i belongs to channel i |
| valid_o | output | NUM_REF | Per-channel qualification flag; 1 = present and in range |

## Verification
The bench builds the block with a 64-cycle gate, count bounds of 15 to 17, an idle limit of 20 cycles and a settling time of 300 cycles. With these values a reference toggling every 4 cycles lands in range, while periods of 3 and 5 cycles fall outside it. Because the whole qualify, lose, re-qualify cycle then spans a few hundred clocks, the run can reach loss of edges, fast and slow rejection, restart of the settling period and threshold chatter, each on one channel while the other stays settled.

// File: rtl/refq_pkg.sv
package refq_pkg;

  // Outcome of one measurement gate.
  typedef struct packed {
    logic done;      // gate closes in this cycle
    logic in_range;  // total edge count within bounds (meaningful with done)
  } gate_res_t;

endpackage

// File: rtl/refq_freq_meter.sv
module refq_freq_meter
  import refq_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = 12_500_000,
  parameter int unsigned CNT_LO      = 1_943_982,
  parameter int unsigned CNT_HI      = 1_944_018
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  output gate_res_t res
);

  localparam int unsigned PH_W  = $clog2(GATE_CYCLES);
  localparam int unsigned CNT_W = $clog2(GATE_CYCLES + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(GATE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(CNT_LO);
  localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(CNT_HI);

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] total;
  logic             gate_end;

  always_comb begin
    gate_end = (ph_q == PH_LAST);
    total    = cnt_q + CNT_W'(rise);
    ph_d     = gate_end ? '0 : ph_q + PH_W'(1);
    cnt_d    = gate_end ? '0 : total;
    res.done     = gate_end;
    res.in_range = (total >= LIM_LO) && (total <= LIM_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/refq_presence.sv
module refq_presence #(
  parameter int unsigned LOS_CYCLES = 50_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic lost
);

  localparam int unsigned IDL_W = $clog2(LOS_CYCLES + 1);
  localparam logic [IDL_W-1:0] IDL_LIM = IDL_W'(LOS_CYCLES);

  logic [IDL_W-1:0] idle_q, idle_d;
  logic             idle_en;

  always_comb begin
    lost    = (idle_q == IDL_LIM);
    idle_en = rise || !lost;
    idle_d  = rise ? '0 : idle_q + IDL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (idle_en) begin
      idle_q <= idle_d;
    end
  end

endmodule

// File: rtl/refq_settle.sv
module refq_settle
  import refq_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 500_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gate_res_t res,
  input  logic      lost,
  output logic      valid
);

  localparam int unsigned STB_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [STB_W-1:0] STB_LIM = STB_W'(STABLE_CYCLES);

  logic             good_q, good_d;
  logic [STB_W-1:0] stb_q, stb_d;
  logic             bad_evt, good_evt, stb_en;

  always_comb begin
    bad_evt  = lost || (res.done && !res.in_range);
    good_evt = res.done && res.in_range && !lost;
    good_d   = bad_evt ? 1'b0 : (good_evt ? 1'b1 : good_q);
    stb_en   = bad_evt || (good_q && (stb_q != STB_LIM));
    stb_d    = bad_evt ? '0 : stb_q + STB_W'(1);
    valid    = good_q && (stb_q == STB_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      good_q <= good_d;
      if (stb_en) stb_q <= stb_d;
    end
  end

endmodule

// File: rtl/refq_channel.sv
module refq_channel
  import refq_pkg::*;
#(
  parameter int unsigned GATE_CYCLES   = 12_500_000,
  parameter int unsigned CNT_LO        = 1_943_982,
  parameter int unsigned CNT_HI        = 1_944_018,
  parameter int unsigned LOS_CYCLES    = 50_000,
  parameter int unsigned STABLE_CYCLES = 500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic valid
);

  logic      ref_q;
  logic      rise;
  logic      lost;
  gate_res_t res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_i;
  end

  assign rise = ref_i && !ref_q;

  refq_freq_meter #(
    .GATE_CYCLES(GATE_CYCLES), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise), .res(res)
  );

  refq_presence #(.LOS_CYCLES(LOS_CYCLES)) u_pres (
    .clk(clk), .rst_n(rst_n), .rise(rise), .lost(lost)
  );

  refq_settle #(.STABLE_CYCLES(STABLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .res(res), .lost(lost), .valid(valid)
  );

endmodule

// File: rtl/refq_top.sv
module refq_top #(
  parameter int unsigned NUM_REF       = 2,
  parameter int unsigned GATE_CYCLES   = 12_500_000,
  parameter int unsigned CNT_LO        = 1_943_982,
  parameter int unsigned CNT_HI        = 1_944_018,
  parameter int unsigned LOS_CYCLES    = 50_000,
  parameter int unsigned STABLE_CYCLES = 500_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_in,
  output logic [NUM_REF-1:0] valid_o
);

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ch
    refq_channel #(
      .GATE_CYCLES(GATE_CYCLES), .CNT_LO(CNT_LO), .CNT_HI(CNT_HI),
      .LOS_CYCLES(LOS_CYCLES), .STABLE_CYCLES(STABLE_CYCLES)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_in[g]), .valid(valid_o[g])
    );
  end

endmodule

// File: rtl/refq_checker.sv
module refq_checker #(
  parameter int unsigned NUM_REF       = 2,
  parameter int unsigned LOS_CYCLES    = 50_000,
  parameter int unsigned STABLE_CYCLES = 500_000_000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REF-1:0] ref_in,
  input logic [NUM_REF-1:0] valid_o
);

  localparam int unsigned IDL_MAX = LOS_CYCLES + 2;
  localparam int unsigned IDL_W   = $clog2(IDL_MAX + 1);
  localparam int unsigned LOW_W   = $clog2(STABLE_CYCLES + 1);
  localparam logic [IDL_W-1:0] IDL_LIM = IDL_W'(IDL_MAX);
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(STABLE_CYCLES);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (valid_o == '0); // R1
    end
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : g_chk
    logic             prev_q;
    logic [IDL_W-1:0] idle_q;
    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        idle_q <= '0;
        low_q  <= '0;
      end else begin
        prev_q <= ref_in[g];
        if (ref_in[g] && !prev_q) idle_q <= '0;
        else if (idle_q != IDL_LIM) idle_q <= idle_q + IDL_W'(1);
        if (valid_o[g]) low_q <= '0;
        else if (low_q != LOW_LIM) low_q <= low_q + LOW_W'(1);
      end
    end

    AST_LOS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_q == IDL_LIM) |-> !valid_o[g]); // R4

    AST_RISE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o[g]) |-> (low_q == LOW_LIM)); // R3

    AST_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_o[g]) |=> !valid_o[g]); // R5
  end

endmodule

bind refq_top refq_checker #(
  .NUM_REF(NUM_REF), .LOS_CYCLES(LOS_CYCLES), .STABLE_CYCLES(STABLE_CYCLES)
) u_refq_checker (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .valid_o(valid_o)
);

// File: tb/refq_top_bench.sv
module refq_top_bench;

  localparam int NREF   = 2;
  localparam int GATE   = 64;
  localparam int LO     = 15;
  localparam int HI     = 17;
  localparam int LOS    = 20;
  localparam int STABLE = 300;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREF-1:0] ref_in = '0;
  logic [NREF-1:0] valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int per [NREF];
  int ph  [NREF];

  // behavioural model state
  int  m_prev [NREF];
  int  m_ph   [NREF];
  int  m_cnt  [NREF];
  int  m_idle [NREF];
  bit  m_good [NREF];
  int  m_stb  [NREF];
  bit  mon1   = 0;
  bit  ch1_drop = 0;

  always #4 clk = ~clk;

  refq_top #(
    .NUM_REF(NREF), .GATE_CYCLES(GATE), .CNT_LO(LO), .CNT_HI(HI),
    .LOS_CYCLES(LOS), .STABLE_CYCLES(STABLE)
  ) u_refq_top (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .valid_o(valid_o)
  );

  function automatic bit model_valid(int c);
    return m_good[c] && (m_stb[c] == STABLE);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference generators
  initial begin
    for (int c = 0; c < NREF; c++) begin per[c] = 4; ph[c] = 0; end
    forever begin
      @(negedge clk);
      for (int c = 0; c < NREF; c++) begin
        if (per[c] == 0) begin
          ref_in[c] = 1'b0; ph[c] = 0;
        end else begin
          if (ph[c] >= per[c]) ph[c] = 0;
          ref_in[c] = (ph[c] < per[c] / 2);
          ph[c] = (ph[c] + 1) % per[c];
        end
      end
    end
  end

  // cycle model: edge counting, gate judgement, idle watchdog, settling
  initial begin
    forever begin
      @(posedge clk);
      for (int c = 0; c < NREF; c++) begin
        if (!rst_n) begin
          m_prev[c] = 0; m_ph[c] = 0; m_cnt[c] = 0;
          m_idle[c] = 0; m_good[c] = 0; m_stb[c] = 0;
        end else begin
          int  rise, total;
          bit  gend, lostf, bad, goodev;
          rise   = (ref_in[c] && m_prev[c] == 0) ? 1 : 0;
          total  = m_cnt[c] + rise;
          gend   = (m_ph[c] == GATE - 1);
          lostf  = (m_idle[c] == LOS);
          bad    = lostf || (gend && (total < LO || total > HI));
          goodev = gend && total >= LO && total <= HI && !lostf;
          if (bad) m_stb[c] = 0;
          else if (m_good[c] && m_stb[c] != STABLE) m_stb[c]++;
          if (bad) m_good[c] = 0;
          else if (goodev) m_good[c] = 1;
          if (rise == 1) m_idle[c] = 0;
          else if (!lostf) m_idle[c]++;
          m_cnt[c]  = gend ? 0 : total;
          m_ph[c]   = gend ? 0 : m_ph[c] + 1;
          m_prev[c] = ref_in[c];
        end
      end
    end
  end

  // compare every cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int c = 0; c < NREF; c++)
          check("R2 model", valid_o[c], model_valid(c));
        if (mon1 && !valid_o[1]) ch1_drop = 1;
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    bit hi;
    cyc(5);
    check("R1 reset", valid_o[0], 1'b0);
    check("R1 reset", valid_o[1], 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 after release", valid_o[0], 1'b0);
    cyc(299);
    check("R3 not before settling", valid_o[0], 1'b0);
    check("R3 not before settling", valid_o[1], 1'b0);
    cyc(500);
    check("R3 settled ch0", valid_o[0], 1'b1);
    check("R3 settled ch1", valid_o[1], 1'b1);
    mon1 = 1;

    per[0] = 0;                 // stop ch0
    cyc(30);
    check("R4 loss drops ch0", valid_o[0], 1'b0);
    check("R7 ch1 unaffected", valid_o[1], 1'b1);
    cyc(10);

    per[0] = 4;                 // return, must resettle
    cyc(200);
    check("R3 restart after loss", valid_o[0], 1'b0);
    cyc(300);
    check("R3 requalified", valid_o[0], 1'b1);

    per[0] = 5;                 // slow
    cyc(140);
    check("R5 out-of-range clears", valid_o[0], 1'b0);
    cyc(400);
    check("R8 slow rejected", valid_o[0], 1'b0);
    per[0] = 3;                 // fast
    cyc(400);
    check("R8 fast rejected", valid_o[0], 1'b0);

    hi = 0;                     // chatter near threshold
    for (int k = 0; k < 16; k++) begin
      per[0] = (k % 2 == 0) ? 4 : 3;
      repeat (96) begin
        @(negedge clk);
        if (valid_o[0]) hi = 1;
      end
    end
    check("R6 chatter never qualifies", hi, 1'b0);
    check("R7 ch1 held through ch0 faults", ch1_drop, 1'b0);
    mon1 = 0;

    per[1] = 0;                 // now fault ch1, recover ch0
    per[0] = 4;
    cyc(30);
    check("R7 ch1 lost", valid_o[1], 1'b0);
    cyc(500);
    check("R7 ch0 qualifies alone", valid_o[0], 1'b1);
    check("R4 ch1 still lost", valid_o[1], 1'b0);
    finish_run();
  end

endmodule